// File: doc/BRIEF.md
# Multipass Recycling Descriptor FIFO

This block holds packet descriptors for a processor in which every packet needs a known number of processing passes. Each clock cycle is one time slot. In each slot the block offers the descriptors at the head of its queue to the processing elements, one per element, together with the number of passes each still needs. At the end of the slot, a dispatched descriptor that was on its last pass leaves the buffer. Any other dispatched descriptor loses one pass and goes back to the tail of the queue. After that, the block takes in at most one newly arriving descriptor.

A new descriptor always gets in while there is room. When the buffer is full, the block finds the stored descriptor with the most passes left. If several share that count, it takes the one nearest the head. The block swaps that descriptor out for the new one if the new one needs strictly fewer passes. Otherwise the new descriptor is refused. The swapped-out descriptor is removed from the middle of the queue, and the others stay in their order. The arrival outcome and the identity of any evicted descriptor are reported in the same cycle as the arrival.

Top module: `mpq_recycle_fifo`

## Requirements
- R1: After reset the occupancy is 0 and every processing-element valid is low.
- R2: In each slot, processing element p (p = 0 .. NPE-1) is offered the p-th queue entry from the head, showing its tag and its remaining pass count, if at least p+1 entries are stored. If fewer are stored, its valid is low.
- R3: A dispatched entry that shows a remaining count of 1 leaves the buffer at the end of the slot.
- R4: A dispatched entry that shows a count above 1 comes back with that count minus one. It is placed behind every undispatched entry. Recycled entries from the same slot follow processing-element index order.
- R5: Recycled entries are enqueued ahead of the slot's arrival.
- R6: An arrival is accepted when the entry count after retirement and recycling is below DEPTH. arr_result is then 1 and the arrival joins the tail.
- R7: With the buffer full after recycling, the victim is the entry with the largest remaining count that is nearest the head. If arr_passes is strictly smaller than the victim's count, arr_result is 2, drop_valid is high with the victim's tag, the victim is removed, the other entries keep their order, and the arrival joins the tail.
- R8: With the buffer full and arr_passes not smaller than the victim's count, arr_result is 3, drop_valid is low and the stored entries are unchanged apart from retirement and recycling.
- R9: With arr_valid low, arr_result is 0 and drop_valid is low.
- R10: The occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | A descriptor arrives this slot |
| arr_tag | input | ID_W | Tag of the arriving descriptor |
| arr_passes | input | PASS_W | Passes the arriving descriptor needs (at least 1) |
| arr_result | output | 2 | Outcome: 0 none, 1 accepted, 2 accepted by eviction, 3 refused |
| drop_valid | output | 1 | A stored descriptor is evicted this slot |
| drop_tag | output | ID_W | Tag of the evicted descriptor |
| pe_valid | output | NPE | Per-element dispatch valid |
| pe_tag | output | NPE*ID_W | Per-element tag, element p at bits p*ID_W |
| pe_left | output | NPE*PASS_W | Per-element remaining passes before this slot's pass |
| occupancy | output | $clog2(DEPTH+1) | Number of stored descriptors |

## Verification
The assertions assume that every arriving descriptor asks for at least one pass, because a zero count has no meaning for a buffer that retires entries when they reach one. One check flags arrivals that break this. The random stimulus draws pass counts from 1 to 12 only. Arrivals come in most slots, and the pass counts are long enough that the buffer fills, so the swap and refuse branches run often. Idle stretches let the queue drain below the number of processing elements. A directed prefix first fills the buffer with equal counts, so the nearest-to-head tie rule is exercised. It then presents both a larger and a smaller arrival.

// File: rtl/mpq_pkg.sv
package mpq_pkg;
    typedef enum logic [1:0] {
        ARR_NONE  = 2'd0,
        ARR_TAKEN = 2'd1,
        ARR_SWAP  = 2'd2,
        ARR_DROP  = 2'd3
    } arr_res_e;
endpackage

// File: rtl/mpq_victim_pick.sv
module mpq_victim_pick #(
    parameter int N  = 8,
    parameter int W  = 4,
    parameter int IW = 3
) (
    input  logic [N-1:0][W-1:0] vals,
    output logic [IW-1:0]       idx,
    output logic [W-1:0]        vmax
);
    // strict compare keeps the entry nearest the head on ties
    always_comb begin
        vmax = vals[0];
        idx  = '0;
        for (int i = 1; i < N; i++) begin
            if (vals[i] > vmax) begin
                vmax = vals[i];
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mpq_recycle_fifo.sv
module mpq_recycle_fifo
    import mpq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NPE    = 2,
    parameter int ID_W   = 6,
    parameter int PASS_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arr_valid,
    input  logic [ID_W-1:0]            arr_tag,
    input  logic [PASS_W-1:0]          arr_passes,
    output logic [1:0]                 arr_result,
    output logic                       drop_valid,
    output logic [ID_W-1:0]            drop_tag,
    output logic [NPE-1:0]             pe_valid,
    output logic [NPE*ID_W-1:0]        pe_tag,
    output logic [NPE*PASS_W-1:0]      pe_left,
    output logic [$clog2(DEPTH+1)-1:0] occupancy
);
    localparam int EW = ID_W + PASS_W;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] ent;
        logic [CW-1:0]            cnt;
    } st_t;

    st_t s_q, s_d;

    logic [CW-1:0]                ndisp_d;
    logic [DEPTH-1:0][EW-1:0]     stage_d;
    logic [CW-1:0]                stcnt_d;
    logic [DEPTH-1:0][PASS_W-1:0] stage_left;
    logic [IW-1:0]                vic_idx;
    logic [PASS_W-1:0]            vic_max;
    arr_res_e                     res_d;

    // retire and recycle: undispatched entries move up, recycled ones follow in PE order
    always_comb begin
        ndisp_d = (s_q.cnt > CW'(NPE)) ? CW'(NPE) : s_q.cnt;
        stage_d = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i + int'(ndisp_d) < int'(s_q.cnt))
                stage_d[i] = s_q.ent[IW'(i + int'(ndisp_d))];
        end
        stcnt_d = s_q.cnt - ndisp_d;
        for (int p = 0; p < NPE; p++) begin
            if (p < int'(ndisp_d) && s_q.ent[p][PASS_W-1:0] > PASS_W'(1)) begin
                stage_d[stcnt_d[IW-1:0]] = {s_q.ent[p][EW-1:PASS_W],
                                            s_q.ent[p][PASS_W-1:0] - PASS_W'(1)};
                stcnt_d = stcnt_d + CW'(1);
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_left
            assign stage_left[g] = stage_d[g][PASS_W-1:0];
        end
    endgenerate

    mpq_victim_pick #(.N(DEPTH), .W(PASS_W), .IW(IW)) u_pick (
        .vals (stage_left),
        .idx  (vic_idx),
        .vmax (vic_max)
    );

    // arrival handling on the staged queue
    always_comb begin
        s_d        = s_q;
        s_d.ent    = stage_d;
        s_d.cnt    = stcnt_d;
        res_d      = ARR_NONE;
        drop_valid = 1'b0;
        drop_tag   = '0;
        if (arr_valid) begin
            if (stcnt_d < CW'(DEPTH)) begin
                res_d = ARR_TAKEN;
                s_d.ent[stcnt_d[IW-1:0]] = {arr_tag, arr_passes};
                s_d.cnt = stcnt_d + CW'(1);
            end else if (arr_passes < vic_max) begin
                res_d      = ARR_SWAP;
                drop_valid = 1'b1;
                drop_tag   = stage_d[vic_idx][EW-1:PASS_W];
                for (int i = 0; i < DEPTH - 1; i++) begin
                    if (IW'(i) >= vic_idx) s_d.ent[i] = stage_d[i+1];
                end
                s_d.ent[DEPTH-1] = {arr_tag, arr_passes};
            end else begin
                res_d = ARR_DROP;
            end
        end
    end

    assign arr_result = res_d;
    assign occupancy  = s_q.cnt;

    generate
        for (genvar p = 0; p < NPE; p++) begin : g_pe
            assign pe_valid[p] = CW'(p) < ndisp_d;
            assign pe_tag[p*ID_W +: ID_W] =
                pe_valid[p] ? s_q.ent[p][EW-1:PASS_W] : '0;
            assign pe_left[p*PASS_W +: PASS_W] =
                pe_valid[p] ? s_q.ent[p][PASS_W-1:0] : '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // ---------------- assertions ----------------
    int fin_ports;
    always_comb begin
        fin_ports = 0;
        for (int p = 0; p < NPE; p++)
            if (pe_valid[p] && pe_left[p*PASS_W +: PASS_W] == PASS_W'(1))
                fin_ports = fin_ports + 1;
    end

    // R10
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    // R2
    pe_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_valid & (pe_valid + NPE'(1))) == '0);

    // R9
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid |-> (arr_result == 2'd0 && !drop_valid));

    // R7
    evict_only_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid |-> arr_result == 2'd2);

    // R7
    swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_result == 2'd2 |=> int'(occupancy) == DEPTH);

    // R8
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_result == 2'd3 |=> int'(occupancy) == DEPTH);

    // R6 R3
    take_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_result == 2'd1 |=>
            int'(occupancy) == int'($past(occupancy)) - $past(fin_ports) + 1);

    // input assumption: arrivals need at least one pass
    pass_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid |-> arr_passes != '0);
endmodule

// File: tb/mpq_recycle_fifo_tb.sv
module mpq_recycle_fifo_tb;
    localparam int DEPTH  = 8;
    localparam int NPE    = 2;
    localparam int ID_W   = 6;
    localparam int PASS_W = 4;
    localparam int CW     = $clog2(DEPTH + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  arr_valid = 1'b0;
    logic [ID_W-1:0]       arr_tag = '0;
    logic [PASS_W-1:0]     arr_passes = '0;
    logic [1:0]            arr_result;
    logic                  drop_valid;
    logic [ID_W-1:0]       drop_tag;
    logic [NPE-1:0]        pe_valid;
    logic [NPE*ID_W-1:0]   pe_tag;
    logic [NPE*PASS_W-1:0] pe_left;
    logic [CW-1:0]         occupancy;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_tag [DEPTH];
    int m_left[DEPTH];
    int m_cnt = 0;
    int next_tag = 0;

    always #4 clk = ~clk;

    mpq_recycle_fifo #(.DEPTH(DEPTH), .NPE(NPE), .ID_W(ID_W), .PASS_W(PASS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_tag(arr_tag),
        .arr_passes(arr_passes), .arr_result(arr_result), .drop_valid(drop_valid),
        .drop_tag(drop_tag), .pe_valid(pe_valid), .pe_tag(pe_tag),
        .pe_left(pe_left), .occupancy(occupancy)
    );

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    // expected outputs from the model state, then advance the model one slot
    task automatic slot(bit v, int tg, int ps);
        int nd, n, vi, vmax, res, dv, dt;
        int nt[DEPTH + NPE];
        int nl[DEPTH + NPE];
        @(negedge clk);
        arr_valid  = v;
        arr_tag    = ID_W'(tg);
        arr_passes = PASS_W'(ps);
        #1;
        nd = (m_cnt < NPE) ? m_cnt : NPE;
        check("R10 occupancy", int'(occupancy), m_cnt);
        for (int p = 0; p < NPE; p++) begin
            check("R2 pe_valid", int'(pe_valid[p]), (p < nd) ? 1 : 0);
            if (p < nd) begin
                check("R2 pe_tag", int'(pe_tag[p*ID_W +: ID_W]), m_tag[p]);
                check("R2 pe_left", int'(pe_left[p*PASS_W +: PASS_W]), m_left[p]);
            end
        end
        n = 0;
        for (int i = nd; i < m_cnt; i++) begin
            nt[n] = m_tag[i]; nl[n] = m_left[i]; n++;
        end
        for (int p = 0; p < nd; p++) begin   // R3 R4
            if (m_left[p] > 1) begin
                nt[n] = m_tag[p]; nl[n] = m_left[p] - 1; n++;
            end
        end
        res = 0; dv = 0; dt = 0;
        if (v) begin                          // R5
            if (n < DEPTH) begin
                res = 1; nt[n] = tg; nl[n] = ps; n++;
            end else begin
                vi = 0; vmax = nl[0];
                for (int i = 1; i < DEPTH; i++)
                    if (nl[i] > vmax) begin vmax = nl[i]; vi = i; end
                if (ps < vmax) begin
                    res = 2; dv = 1; dt = nt[vi];
                    for (int i = vi; i < DEPTH - 1; i++) begin
                        nt[i] = nt[i+1]; nl[i] = nl[i+1];
                    end
                    nt[DEPTH-1] = tg; nl[DEPTH-1] = ps;
                end else begin
                    res = 3;
                end
            end
        end
        check(v ? "R6/R7/R8 arr_result" : "R9 arr_result", int'(arr_result), res);
        check(v ? "R7/R8 drop_valid" : "R9 drop_valid", int'(drop_valid), dv);
        if (dv) check("R7 drop_tag", int'(drop_tag), dt);
        m_cnt = n;
        for (int i = 0; i < n; i++) begin m_tag[i] = nt[i]; m_left[i] = nl[i]; end
        @(posedge clk);
    endtask

    task automatic arrive(int ps);
        slot(1'b1, next_tag, ps);
        next_tag = (next_tag + 1) % (1 << ID_W);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 occupancy", int'(occupancy), 0);
        check("R1 pe_valid", int'(pe_valid), 0);
        rst_n = 1'b1;
        // directed: single entry, only one PE busy
        arrive(3);
        slot(1'b0, 0, 0);
        slot(1'b0, 0, 0);
        slot(1'b0, 0, 0);
        slot(1'b0, 0, 0);
        // fill with equal counts: tie keeps the entry nearest the head
        for (int i = 0; i < 12; i++) arrive(12);
        arrive(15);          // R8 refused
        arrive(1);           // R7 eviction
        arrive(2);           // R7 eviction again
        for (int i = 0; i < 20; i++) slot(1'b0, 0, 0);
        // random traffic with idle stretches
        for (int i = 0; i < 4000; i++) begin
            if ((i % 500) > 460) slot(1'b0, 0, 0);
            else if (($urandom % 4) != 0) arrive(1 + int'($urandom % 12));
            else slot(1'b0, 0, 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule